// File: doc/BRIEF.md
# Keypad Report Reader with Multi-Press Filter

This block is the host-side engine that fetches the button state of a 23-key controller (eight standard buttons plus a fifteen-key keypad) over a three-line shared port. A one-cycle start pulse makes it walk the port through an arm word, a select word and then twenty-four clock-low/clock-high pairs. It samples the returned data line once per pair and builds a 24-bit raw report, least significant bit first.

After the last bit the report goes through a filter. The filter ignores four exempt positions (8, 9, 16 and 17). If two or more of the remaining positions read as pressed, the whole report is replaced by zero. Otherwise it passes unchanged. The raw and filtered reports are presented together with a one-cycle done strobe. Every port word is held for a parameterised number of system clocks, so that a slow peripheral can follow.

Top module: `kpad_reader`

## Requirements
- R1: After reset, port_o is 3'b100 (bit 2 high, bits 1 and 0 low), busy_o and done_o are 0, and raw_o and report_o are all zeros.
- R2: A start pulse seen while idle makes port_o equal 3'b101 on the next cycle: bit 2 set, bit 1 clear and bit 0 set in one word. busy_o rises in the same cycle.
- R3: After the arm word has been held for HOLD_CYCLES cycles, bit 1 is set (port_o = 3'b111) and held for HOLD_CYCLES cycles before the first bit is read.
- R4: Each report bit takes one clock-low word 3'b011 followed by one clock-high word 3'b111, each held for HOLD_CYCLES cycles. Exactly REPORT_BITS clock-low words occur per transfer, and while busy port_o takes no value other than 3'b101, 3'b111 and 3'b011.
- R5: line_i is sampled in the last cycle of each clock-low word. Sample k (counting from 0) is stored in raw_o bit k, and 1 means pressed.
- R6: done_o is high for exactly one cycle, 50*HOLD_CYCLES+2 cycles after the start edge. In that cycle busy_o is 0 and port_o has returned to 3'b100.
- R7: If at most one bit outside the exempt positions 8, 9, 16 and 17 is 1, report_o equals raw_o in the done cycle. This holds for any combination of the exempt bits.
- R8: If two or more bits outside the exempt positions are 1, report_o is all zeros in the done cycle, while raw_o still shows the sampled value.
- R9: A start pulse during a transfer is ignored. No second arm word appears, and the transfer gives a single done strobe with an undisturbed report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to read the controller |
| line_i | input | 1 | Data line read back from port bit 0 |
| port_o | output | 3 | Port word: bit 2 read clock, bit 1 select/latch, bit 0 data release |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle strobe marking valid reports |
| raw_o | output | 24 | Report as sampled |
| report_o | output | 24 | Report after the multi-press filter |

## Verification
The assertions assume that line_i comes from a peripheral that follows the port. They also assume start_i is a synchronous pulse with no relation to line_i. None of them depends on the data values, because the filter properties compare report_o with raw_o in the done cycle only. The stimulus drives start_i and the model's line only on falling clock edges, and the model advances its bit pointer only on a rising port clock while select is high. line_i therefore never changes in the cycle the engine samples it.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SEL,
        ST_LOW,
        ST_HIGH,
        ST_FINISH
    } kp_state_e;

    // port word layout: [2] read clock, [1] select/latch, [0] data release
    localparam logic [2:0] PORT_REST = 3'b100;
    localparam logic [2:0] PORT_ARM  = 3'b101;
    localparam logic [2:0] PORT_SEL  = 3'b111;
    localparam logic [2:0] PORT_LOW  = 3'b011;

endpackage

// File: rtl/kpad_phase_timer.sv
module kpad_phase_timer #(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expire_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CW'(HOLD_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/kpad_report_filter.sv
module kpad_report_filter #(
    parameter int                     REPORT_BITS = 24,
    parameter logic [REPORT_BITS-1:0] EXEMPT_MASK = 24'h030300
) (
    input  logic [REPORT_BITS-1:0] raw_i,
    output logic [REPORT_BITS-1:0] report_o
);
    localparam int CW = $clog2(REPORT_BITS + 1);

    logic [CW-1:0] hits;

    always_comb begin
        hits = '0;
        for (int i = 0; i < REPORT_BITS; i++) begin
            if (!EXEMPT_MASK[i]) begin
                hits = hits + CW'(raw_i[i]);
            end
        end
        report_o = (hits >= CW'(2)) ? '0 : raw_i;
    end

endmodule

// File: rtl/kpad_reader.sv
module kpad_reader #(
    parameter int                     REPORT_BITS = 24,
    parameter int                     HOLD_CYCLES = 4,
    parameter logic [REPORT_BITS-1:0] EXEMPT_MASK = 24'h030300
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   line_i,
    output logic [2:0]             port_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [REPORT_BITS-1:0] raw_o,
    output logic [REPORT_BITS-1:0] report_o
);
    import kpad_pkg::*;

    localparam int IW = $clog2(REPORT_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(REPORT_BITS - 1);

    typedef struct packed {
        kp_state_e              state;
        logic [2:0]             port;
        logic [IW-1:0]          idx;
        logic [REPORT_BITS-1:0] raw;
        logic [REPORT_BITS-1:0] report;
        logic                   done;
    } regs_t;

    regs_t r_d, r_q;
    logic  load;
    logic  expire;
    logic [REPORT_BITS-1:0] filtered;

    kpad_phase_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .expire_o(expire)
    );

    kpad_report_filter #(
        .REPORT_BITS(REPORT_BITS),
        .EXEMPT_MASK(EXEMPT_MASK)
    ) filter_i (
        .raw_i   (r_q.raw),
        .report_o(filtered)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load     = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_ARM;
                    r_d.port  = PORT_ARM;
                    r_d.raw   = '0;
                    load      = 1'b1;
                end
            end
            ST_ARM: begin
                if (expire) begin
                    r_d.state = ST_SEL;
                    r_d.port  = PORT_SEL;
                    load      = 1'b1;
                end
            end
            ST_SEL: begin
                if (expire) begin
                    r_d.state = ST_LOW;
                    r_d.port  = PORT_LOW;
                    r_d.idx   = '0;
                    load      = 1'b1;
                end
            end
            ST_LOW: begin
                if (expire) begin
                    r_d.raw[r_q.idx] = line_i;
                    r_d.state        = ST_HIGH;
                    r_d.port         = PORT_SEL;
                    load             = 1'b1;
                end
            end
            ST_HIGH: begin
                if (expire) begin
                    if (r_q.idx == LAST_IDX) begin
                        r_d.state = ST_FINISH;
                    end else begin
                        r_d.idx   = r_q.idx + 1'b1;
                        r_d.state = ST_LOW;
                        r_d.port  = PORT_LOW;
                        load      = 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                r_d.report = filtered;
                r_d.done   = 1'b1;
                r_d.port   = PORT_REST;
                r_d.state  = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.port  = PORT_REST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.port   <= PORT_REST;
            r_q.idx    <= '0;
            r_q.raw    <= '0;
            r_q.report <= '0;
            r_q.done   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign port_o   = r_q.port;
    assign busy_o   = (r_q.state != ST_IDLE);
    assign done_o   = r_q.done;
    assign raw_o    = r_q.raw;
    assign report_o = r_q.report;

endmodule

// File: rtl/kpad_reader_chk.sv
module kpad_reader_chk #(
    parameter int                     REPORT_BITS = 24,
    parameter int                     HOLD_CYCLES = 4,
    parameter logic [REPORT_BITS-1:0] EXEMPT_MASK = 24'h030300
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic [2:0]             port_o,
    input logic                   busy_o,
    input logic                   done_o,
    input logic [REPORT_BITS-1:0] raw_o,
    input logic [REPORT_BITS-1:0] report_o
);
    logic [2:0]  prev_port_q;
    logic [15:0] run_q;
    logic        prev_busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_port_q <= 3'b100;
            run_q       <= '0;
            prev_busy_q <= 1'b0;
        end else begin
            prev_port_q <= port_o;
            prev_busy_q <= busy_o;
            if (port_o != prev_port_q) begin
                run_q <= '0;
            end else if (run_q != 16'hFFFF) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    p_arm_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (port_o == 3'b101 && busy_o));

    p_legal_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (port_o == 3'b101 || port_o == 3'b111 || port_o == 3'b011));

    p_hold_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_busy_q && port_o != prev_port_q) |-> (run_q >= 16'(HOLD_CYCLES - 1)));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (port_o == 3'b100 && !busy_o));

    p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $countones(raw_o & ~EXEMPT_MASK) < 2) |-> (report_o == raw_o));

    p_nulled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $countones(raw_o & ~EXEMPT_MASK) >= 2) |-> (report_o == '0));

    p_no_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_busy_q && busy_o && prev_port_q != 3'b101) |-> (port_o != 3'b101));

endmodule

bind kpad_reader kpad_reader_chk #(
    .REPORT_BITS(REPORT_BITS),
    .HOLD_CYCLES(HOLD_CYCLES),
    .EXEMPT_MASK(EXEMPT_MASK)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .port_o  (port_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .raw_o   (raw_o),
    .report_o(report_o)
);

// File: tb/kpad_reader_tb_top.sv
module kpad_reader_tb_top;
    localparam int HOLD = 4;
    localparam int NB   = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          line_i;
    logic [2:0]    port_o;
    logic          busy_o, done_o;
    logic [NB-1:0] raw_o, report_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // peripheral model state
    logic [NB-1:0] pad_rep = '0;
    int            pad_idx = 0;
    int            low_cnt = 0;
    int            arm_cnt = 0;
    int            done_cnt = 0;
    logic [2:0]    seen_port = 3'b100;

    always #4 clk = ~clk;

    kpad_reader #(.REPORT_BITS(NB), .HOLD_CYCLES(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_i(line_i),
        .port_o(port_o), .busy_o(busy_o), .done_o(done_o),
        .raw_o(raw_o), .report_o(report_o)
    );

    assign line_i = port_o[0] & ((pad_idx < NB) ? pad_rep[pad_idx] : 1'b0);

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (port_o[1] && !seen_port[1] && port_o[0]) pad_idx <= 0;
        else if (port_o[2] && !seen_port[2] && port_o[1]) pad_idx <= pad_idx + 1;
        if (!port_o[2] && seen_port[2] && port_o[1]) low_cnt <= low_cnt + 1;
        if (port_o == 3'b101) arm_cnt <= arm_cnt + 1;
        if (done_o) done_cnt <= done_cnt + 1;
        seen_port <= port_o;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] expect_filter(input logic [NB-1:0] r);
        int n = 0;
        for (int i = 0; i < NB; i++)
            if (r[i] && !(i == 8 || i == 9 || i == 16 || i == 17)) n++;
        return (n >= 2) ? '0 : r;
    endfunction

    // runs one transfer, returns latency of done in negedges after start
    task automatic run_read(input logic [NB-1:0] pat, input int glitch_at, output int lat);
        pad_rep = pat;
        @(negedge clk);
        low_cnt = 0; arm_cnt = 0; done_cnt = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 2000) begin
            if (lat == glitch_at) start_i = 1'b1;
            else start_i = 1'b0;
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
    endtask

    task automatic t_reset;
        chk(port_o == 3'b100, "R1 port", 32'(port_o), 32'h4);
        chk(!busy_o && !done_o, "R1 flags", {30'd0, busy_o, done_o}, 32'h0);
        chk(raw_o == '0 && report_o == '0, "R1 reports", 32'(raw_o | report_o), 32'h0);
    endtask

    task automatic t_sequence;
        pad_rep = '0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(port_o == 3'b101 && busy_o, "R2 arm word", 32'(port_o), 32'h5);
        for (int i = 1; i < HOLD; i++) @(negedge clk);
        chk(port_o == 3'b101, "R2 arm held", 32'(port_o), 32'h5);
        @(negedge clk);
        chk(port_o == 3'b111, "R3 select word", 32'(port_o), 32'h7);
        for (int i = 1; i < HOLD; i++) @(negedge clk);
        chk(port_o == 3'b111, "R3 select held", 32'(port_o), 32'h7);
        @(negedge clk);
        chk(port_o == 3'b011, "R4 first low", 32'(port_o), 32'h3);
        while (!done_o && cycles < 150000) @(negedge clk);
    endtask

    task automatic t_read(input logic [NB-1:0] pat, input string name);
        int lat;
        run_read(pat, -1, lat);
        chk(raw_o == pat, {"R5 raw ", name}, 32'(raw_o), 32'(pat));
        chk(report_o == expect_filter(pat), {"R7/R8 report ", name}, 32'(report_o), 32'(expect_filter(pat)));
        chk(lat == 50 * HOLD + 2, {"R6 latency ", name}, 32'(lat), 32'(50 * HOLD + 2));
        chk(low_cnt == NB, {"R4 low count ", name}, 32'(low_cnt), 32'(NB));
        @(negedge clk);
        chk(!done_o && port_o == 3'b100 && done_cnt == 1, {"R6 single strobe ", name},
            32'(done_cnt), 32'h1);
    endtask

    task automatic t_busy_start;
        int lat;
        logic [NB-1:0] pat = 24'h000020;
        run_read(pat, 37, lat);
        chk(arm_cnt == HOLD, "R9 arm count", 32'(arm_cnt), 32'(HOLD));
        chk(raw_o == pat && report_o == pat, "R9 report", 32'(report_o), 32'(pat));
        @(negedge clk);
        chk(done_cnt == 1 && !busy_o, "R9 one done", 32'(done_cnt), 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sequence();
        @(negedge clk);
        t_read(24'h000000, "empty");
        t_read(24'h000008, "one std button");
        t_read(24'h030300, "all exempt");                // R7
        t_read(24'h130300, "exempt plus keypad");        // R7
        t_read(24'h000003, "two std buttons");           // R8
        t_read(24'hA5C0F1, "many keys");                 // R8
        t_read(24'h800001, "first and last");            // R8
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule